// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block runs complete I2C master transactions on behalf of a requester by driving the register port of a byte-level I2C controller. It is given a chip address, an operation, up to four register-address bytes and a data length. It then issues the START, address, data and STOP commands one step at a time. After each command it polls the controller's interrupt flag and compares the reported status byte with the exact code that step should produce.

If a status differs from the expected code, or if the flag never rises, the transaction ends at once. A STOP is still issued in that case. Every transaction finishes with a one-cycle done pulse and a 32-bit result word. The word is zero on success. On failure it packs the error class together with the last control byte, the status seen and the status that was expected. Write data is pulled from a byte stream, and read data is pushed out on another.

Polling is paced by a poll interval counter (`POLL_INTERVAL` clock cycles between polls). A step is abandoned after `POLL_LIMIT` polls that find nothing. Both are parameters, so a real bus period and the bench's short windows share one implementation.

Top module: `i2c_txn_sequencer`

## Requirements
- R1: `result` is {class[31:24], control[23:16], status[15:8], expected[7:0]} and is all zero on success. Class 8'h01 means a status mismatch; its control field is the last control byte written OR 8'h08. Class 8'h02 means a timeout; its control field is the last control byte written.
- R2: After each command, the sequencer samples the flag (or, after STOP, the status) once every POLL_INTERVAL cycles, with the first sample POLL_INTERVAL cycles after the command write. If POLL_LIMIT samples all miss, the step fails with class 8'h02. A flag that becomes visible before the last sample is accepted.
- R3: Control bytes use enable = bit 6, start = bit 5, stop = bit 4, flag = bit 3 (always written 0) and ack = bit 2. START and repeated START write 8'h60. Byte sends write 8'h40 with a data write. Receives write 8'h44 (ACK) or 8'h40 (NAK). STOP writes 8'h50.
- R4: The chip byte is {chip[6:0], rw}, with rw = 1 in the read phase. Its expected status is 8'h40 when rw = 1 and 8'h18 when rw = 0.
- R5: A write (`reqOp` 0 or 3) sends: START (expect 8'h08), the chip byte, the address bytes least significant first, then `reqLen` bytes from `txByte`, each byte expecting 8'h28. `txTake` pulses once per byte consumed.
- R6: A read (`reqOp` 1) with `reqAddrLen` > 0 first sends START, the chip byte with rw = 0 and the address bytes. It then sends a repeated START expecting 8'h10, with no STOP in between, followed by the chip byte with rw = 1.
- R7: A read with `reqAddrLen` = 0 begins with a plain START (expect 8'h08) and the chip byte with rw = 1.
- R8: Each received byte except the last is ACKed (expect 8'h50). The last byte is NAKed (expect 8'h58). Every received byte appears once on `rxByte` with an `rxValid` pulse, in order.
- R9: A probe (`reqOp` 2) is a read of one NAKed byte with no address bytes, followed by STOP.
- R10: On the first mismatch or timeout, no further START, address or data step is issued; the next command is STOP.
- R11: STOP is always issued and its completion is status 8'hF8. A STOP timeout gives result {8'h02, 8'h50, status, 8'hF8}, but only when no earlier step failed; otherwise the first error is kept.
- R12: After reset `busy` and `done` are 0. `done` is high for exactly one cycle per transaction, and `busy` falls after it. `reqValid` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a transaction (accepted only when idle) |
| reqOp | input | 2 | 0/3 write, 1 read, 2 probe |
| reqChip | input | 7 | 7-bit chip address |
| reqAddrLen | input | 3 | Number of address bytes, 0..4 (larger values act as 4) |
| reqAddr | input | 32 | Address bytes, least significant sent first |
| reqLen | input | LEN_W | Data byte count |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed result, valid while done is high |
| txByte | input | 8 | Next write data byte |
| txTake | output | 1 | txByte consumed this cycle |
| rxValid | output | 1 | rxByte holds a received byte |
| rxByte | output | 8 | Received byte |
| busCtrlWr | output | 1 | Write the controller's control register |
| busDataWr | output | 1 | Write the controller's data register |
| busCtrl | output | 8 | Control byte |
| busTx | output | 8 | Data register byte |
| busFlag | input | 1 | Controller interrupt flag |
| busStatus | input | 8 | Controller status register |
| busRx | input | 8 | Controller data register (read) |

## Verification
The hardest situations to reach are the poll-window edges, and an error that is followed by a STOP that also never completes. The bench drives a behavioural controller whose response delay, faulting step and hanging step can be programmed. A delay of one cycle less than POLL_LIMIT·POLL_INTERVAL must pass, and a delay exactly equal to it must time out. A fault injected on the chip byte, combined with a STOP that never reaches 8'hF8, shows that the first error survives. The command log recorded by the model confirms the exact byte order, including the repeated START with no STOP before it.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // control register bit masks (decoded by the byte controller)
  localparam logic [7:0] CB_ACK   = 8'h04;
  localparam logic [7:0] CB_FLAG  = 8'h08;
  localparam logic [7:0] CB_STOP  = 8'h10;
  localparam logic [7:0] CB_START = 8'h20;
  localparam logic [7:0] CB_EN    = 8'h40;

  // status codes expected from the controller
  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RESTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NAK  = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  localparam logic [7:0] CLS_MISMATCH = 8'h01;
  localparam logic [7:0] CLS_TIMEOUT  = 8'h02;

  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_PROBE = 2'd2;

  typedef enum logic [2:0] {
    K_NONE, K_START, K_RSTART, K_CHIP, K_ABYTE, K_DBYTE, K_RECV, K_STOP
  } stepKind_t;

  typedef struct packed {
    logic      load;
    stepKind_t issue;
    logic      waitFlag;
    logic      waitStop;
  } seqStrobe_t;

endpackage

// File: rtl/i2cseq_datapath.sv
module i2cseq_datapath
  import i2cseq_pkg::*;
#(
  parameter int POLL_INTERVAL = 2000,
  parameter int POLL_LIMIT    = 1000,
  parameter int LEN_W         = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [1:0]       reqOp,
  input  logic [6:0]       reqChip,
  input  logic [2:0]       reqAddrLen,
  input  logic [31:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       txByte,
  input  logic             busFlag,
  input  logic [7:0]       busStatus,
  input  logic [7:0]       busRx,
  output logic             busCtrlWr,
  output logic             busDataWr,
  output logic [7:0]       busCtrl,
  output logic [7:0]       busTx,
  output logic             txTake,
  output logic             rxValid,
  output logic [7:0]       rxByte,
  output logic [31:0]      result,
  output logic             pollHit,
  output logic             pollErr,
  output logic             stopEnd,
  output logic             readPhase,
  output logic             opWrite,
  output logic             addrLeftNz,
  output logic             lenLeftNz
);

  localparam int TW = $clog2(POLL_INTERVAL + 1);
  localparam int MW = $clog2(POLL_LIMIT + 1);
  localparam logic [TW-1:0] TIMER_RELOAD = TW'(POLL_INTERVAL - 1);
  localparam logic [MW-1:0] MISS_LAST    = MW'(POLL_LIMIT - 1);

  logic [6:0]       chipR;
  logic [2:0]       addrLeft;
  logic [31:0]      addrSh;
  logic [LEN_W-1:0] lenLeft;
  logic [7:0]       lastCtrl;
  logic [7:0]       expStat;
  logic             lastRecv;
  logic             errSeen;
  logic [TW-1:0]    pollTimer;
  logic [MW-1:0]    missCnt;

  logic [7:0] ctrlByte, dataByte, expNext;
  logic       dataWr;
  logic       isRead, isProbe;
  logic [2:0] loadAlen;
  logic       waiting, pollTick, found;
  logic       flagBad, flagTo, stopSeen, stopTo;

  assign isProbe  = (reqOp == OP_PROBE);
  assign isRead   = (reqOp == OP_READ) || isProbe;
  assign loadAlen = isProbe ? 3'd0 : ((reqAddrLen > 3'd4) ? 3'd4 : reqAddrLen);

  // command byte and expected status for the step being issued
  always_comb begin
    ctrlByte = 8'h00;
    dataByte = 8'h00;
    dataWr   = 1'b0;
    expNext  = expStat;
    unique case (strobe.issue)
      K_START:  begin ctrlByte = CB_EN | CB_START; expNext = ST_START; end
      K_RSTART: begin ctrlByte = CB_EN | CB_START; expNext = ST_RESTART; end
      K_CHIP: begin
        ctrlByte = CB_EN;
        dataByte = {chipR, readPhase};
        dataWr   = 1'b1;
        expNext  = readPhase ? ST_AR_ACK : ST_AW_ACK;
      end
      K_ABYTE: begin
        ctrlByte = CB_EN; dataByte = addrSh[7:0]; dataWr = 1'b1; expNext = ST_DW_ACK;
      end
      K_DBYTE: begin
        ctrlByte = CB_EN; dataByte = txByte; dataWr = 1'b1; expNext = ST_DW_ACK;
      end
      K_RECV: begin
        ctrlByte = (lenLeft > LEN_W'(1)) ? (CB_EN | CB_ACK) : CB_EN;
        expNext  = (lenLeft > LEN_W'(1)) ? ST_DR_ACK : ST_DR_NAK;
      end
      K_STOP:   begin ctrlByte = CB_EN | CB_STOP; expNext = ST_IDLE; end
      default:  ;
    endcase
  end

  assign busCtrlWr = (strobe.issue != K_NONE);
  assign busDataWr = dataWr;
  assign busCtrl   = ctrlByte;
  assign busTx     = dataByte;
  assign txTake    = (strobe.issue == K_DBYTE);

  // poll window
  assign waiting  = strobe.waitFlag | strobe.waitStop;
  assign pollTick = waiting && (pollTimer == '0);
  assign found    = strobe.waitFlag ? busFlag : (busStatus == ST_IDLE);
  assign pollHit  = strobe.waitFlag && pollTick && busFlag && (busStatus == expStat);
  assign flagBad  = strobe.waitFlag && pollTick && busFlag && (busStatus != expStat);
  assign flagTo   = strobe.waitFlag && pollTick && !busFlag && (missCnt == MISS_LAST);
  assign stopSeen = strobe.waitStop && pollTick && (busStatus == ST_IDLE);
  assign stopTo   = strobe.waitStop && pollTick && (busStatus != ST_IDLE) && (missCnt == MISS_LAST);
  assign pollErr  = flagBad | flagTo;
  assign stopEnd  = stopSeen | stopTo;

  assign addrLeftNz = (addrLeft != 3'd0);
  assign lenLeftNz  = (lenLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opWrite   <= 1'b1;
      chipR     <= '0;
      addrLeft  <= '0;
      addrSh    <= '0;
      lenLeft   <= '0;
      readPhase <= 1'b0;
      lastCtrl  <= '0;
      expStat   <= '0;
      lastRecv  <= 1'b0;
      errSeen   <= 1'b0;
      result    <= '0;
      pollTimer <= '0;
      missCnt   <= '0;
      rxValid   <= 1'b0;
      rxByte    <= '0;
    end else begin
      rxValid <= pollHit && lastRecv;
      if (pollHit && lastRecv) rxByte <= busRx;

      if (strobe.load) begin
        opWrite   <= !isRead;
        chipR     <= reqChip;
        addrLeft  <= loadAlen;
        addrSh    <= reqAddr;
        lenLeft   <= isProbe ? LEN_W'(1) : reqLen;
        readPhase <= isRead && (loadAlen == 3'd0);
        errSeen   <= 1'b0;
        result    <= '0;
      end

      if (strobe.issue != K_NONE) begin
        lastCtrl  <= ctrlByte;
        expStat   <= expNext;
        lastRecv  <= (strobe.issue == K_RECV);
        pollTimer <= TIMER_RELOAD;
        missCnt   <= '0;
        if (strobe.issue == K_ABYTE) begin
          addrSh   <= addrSh >> 8;
          addrLeft <= addrLeft - 3'd1;
        end
        if (strobe.issue == K_DBYTE || strobe.issue == K_RECV) lenLeft <= lenLeft - LEN_W'(1);
        if (strobe.issue == K_RSTART) readPhase <= 1'b1;
      end else if (waiting) begin
        if (pollTimer != '0) begin
          pollTimer <= pollTimer - TW'(1);
        end else begin
          pollTimer <= TIMER_RELOAD;
          if (!found) missCnt <= missCnt + MW'(1);
        end
      end

      if (flagBad) begin
        result  <= {CLS_MISMATCH, lastCtrl | CB_FLAG, busStatus, expStat};
        errSeen <= 1'b1;
      end else if (flagTo) begin
        result  <= {CLS_TIMEOUT, lastCtrl, busStatus, expStat};
        errSeen <= 1'b1;
      end else if (stopTo && !errSeen) begin
        result  <= {CLS_TIMEOUT, lastCtrl, busStatus, ST_IDLE};
      end
    end
  end

endmodule

// File: rtl/i2cseq_control.sv
module i2cseq_control
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pollHit,
  input  logic       pollErr,
  input  logic       stopEnd,
  input  logic       readPhase,
  input  logic       opWrite,
  input  logic       addrLeftNz,
  input  logic       lenLeftNz,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_RSTART, S_CHIP, S_ABYTE, S_DBYTE, S_RECV,
    S_WAIT, S_STOP, S_SWAIT, S_DONE
  } seqState_t;

  seqState_t state, stNext, afterHit;
  stepKind_t prevKind;

  // where to go once the issued step reported its expected status
  always_comb begin
    afterHit = S_STOP;
    unique case (prevKind)
      K_START, K_RSTART: afterHit = S_CHIP;
      K_CHIP, K_ABYTE: begin
        if (readPhase)       afterHit = lenLeftNz ? S_RECV : S_STOP;
        else if (addrLeftNz) afterHit = S_ABYTE;
        else if (opWrite)    afterHit = lenLeftNz ? S_DBYTE : S_STOP;
        else                 afterHit = S_RSTART;
      end
      K_DBYTE: afterHit = lenLeftNz ? S_DBYTE : S_STOP;
      K_RECV:  afterHit = lenLeftNz ? S_RECV : S_STOP;
      default: afterHit = S_STOP;
    endcase
  end

  always_comb begin
    strobe = '0;
    stNext = state;
    unique case (state)
      S_IDLE:   if (reqValid) begin strobe.load = 1'b1; stNext = S_START; end
      S_START:  begin strobe.issue = K_START;  stNext = S_WAIT; end
      S_RSTART: begin strobe.issue = K_RSTART; stNext = S_WAIT; end
      S_CHIP:   begin strobe.issue = K_CHIP;   stNext = S_WAIT; end
      S_ABYTE:  begin strobe.issue = K_ABYTE;  stNext = S_WAIT; end
      S_DBYTE:  begin strobe.issue = K_DBYTE;  stNext = S_WAIT; end
      S_RECV:   begin strobe.issue = K_RECV;   stNext = S_WAIT; end
      S_WAIT: begin
        strobe.waitFlag = 1'b1;
        if (pollErr)      stNext = S_STOP;
        else if (pollHit) stNext = afterHit;
      end
      S_STOP:  begin strobe.issue = K_STOP; stNext = S_SWAIT; end
      S_SWAIT: begin strobe.waitStop = 1'b1; if (stopEnd) stNext = S_DONE; end
      S_DONE:  stNext = S_IDLE;
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      prevKind <= K_NONE;
    end else begin
      state <= stNext;
      if (strobe.issue != K_NONE) prevKind <= strobe.issue;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/i2c_txn_sequencer.sv
module i2c_txn_sequencer
  import i2cseq_pkg::*;
#(
  parameter int POLL_INTERVAL = 2000,
  parameter int POLL_LIMIT    = 1000,
  parameter int LEN_W         = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [6:0]       reqChip,
  input  logic [2:0]       reqAddrLen,
  input  logic [31:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             busy,
  output logic             done,
  output logic [31:0]      result,
  input  logic [7:0]       txByte,
  output logic             txTake,
  output logic             rxValid,
  output logic [7:0]       rxByte,
  output logic             busCtrlWr,
  output logic             busDataWr,
  output logic [7:0]       busCtrl,
  output logic [7:0]       busTx,
  input  logic             busFlag,
  input  logic [7:0]       busStatus,
  input  logic [7:0]       busRx
);

  seqStrobe_t strobe;
  logic pollHit, pollErr, stopEnd, readPhase, opWrite, addrLeftNz, lenLeftNz;

  i2cseq_control u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .pollHit(pollHit), .pollErr(pollErr), .stopEnd(stopEnd),
    .readPhase(readPhase), .opWrite(opWrite),
    .addrLeftNz(addrLeftNz), .lenLeftNz(lenLeftNz),
    .strobe(strobe), .busy(busy), .done(done)
  );

  i2cseq_datapath #(
    .POLL_INTERVAL(POLL_INTERVAL), .POLL_LIMIT(POLL_LIMIT), .LEN_W(LEN_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqOp(reqOp), .reqChip(reqChip), .reqAddrLen(reqAddrLen),
    .reqAddr(reqAddr), .reqLen(reqLen), .txByte(txByte),
    .busFlag(busFlag), .busStatus(busStatus), .busRx(busRx),
    .busCtrlWr(busCtrlWr), .busDataWr(busDataWr), .busCtrl(busCtrl), .busTx(busTx),
    .txTake(txTake), .rxValid(rxValid), .rxByte(rxByte), .result(result),
    .pollHit(pollHit), .pollErr(pollErr), .stopEnd(stopEnd),
    .readPhase(readPhase), .opWrite(opWrite),
    .addrLeftNz(addrLeftNz), .lenLeftNz(lenLeftNz)
  );

endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        busy,
  input logic        done,
  input logic [31:0] result,
  input logic        txTake,
  input logic        rxValid,
  input logic        busCtrlWr,
  input logic        busDataWr,
  input logic [7:0]  busCtrl
);

  // R3: a data register write always travels with a control write
  a_r3_data_with_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    busDataWr |-> busCtrlWr);

  // R5: a consumed write byte is placed in the data register
  a_r5_take_is_send: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> busDataWr);

  // R11: after a STOP command nothing is written until it has been polled
  a_r11_stop_then_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busCtrlWr && busCtrl[4]) |=> !busCtrlWr);

  // R1: a success class means the whole word is zero
  a_r1_success_all_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && result[31:24] == 8'h00) |-> (result == 32'h0));

  // R1: only the defined classes are reported
  a_r1_class_known: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result[31:24] <= 8'h02));

  // R12: done lasts one cycle and the block then goes idle
  a_r12_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R12: a transaction only starts from a request
  a_r12_start_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  // R12: no bus command while idle
  a_r12_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busCtrlWr);

  // R8: received bytes only appear during a transaction
  a_r8_rx_in_txn: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> busy);

endmodule

bind i2c_txn_sequencer i2cseq_checker u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .result(result), .txTake(txTake), .rxValid(rxValid),
  .busCtrlWr(busCtrlWr), .busDataWr(busDataWr), .busCtrl(busCtrl)
);

// File: tb/test_i2c_txn_sequencer.sv
`timescale 1ns/1ps
module test_i2c_txn_sequencer;

  localparam int PI = 4;
  localparam int PL = 8;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = '0;
  logic [6:0]    reqChip = '0;
  logic [2:0]    reqAddrLen = '0;
  logic [31:0]   reqAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic busy, done, txTake, rxValid, busCtrlWr, busDataWr;
  logic [31:0] result;
  logic [7:0]  rxByte, busCtrl, busTx, txByte;
  logic        mFlag;
  logic [7:0]  mStatus, mRx;

  i2c_txn_sequencer #(.POLL_INTERVAL(PI), .POLL_LIMIT(PL), .LEN_W(LW)) i_i2c_txn_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqChip(reqChip),
    .reqAddrLen(reqAddrLen), .reqAddr(reqAddr), .reqLen(reqLen),
    .busy(busy), .done(done), .result(result), .txByte(txByte), .txTake(txTake),
    .rxValid(rxValid), .rxByte(rxByte), .busCtrlWr(busCtrlWr), .busDataWr(busDataWr),
    .busCtrl(busCtrl), .busTx(busTx), .busFlag(mFlag), .busStatus(mStatus), .busRx(mRx)
  );

  int checks = 0;
  int failures = 0;

  // ---------------- behavioural byte controller ----------------
  logic       mClr = 1'b0;
  int         mDelay = 3;
  int         faultStep = 99;
  int         hangStep = 99;
  logic       stopHang = 1'b0;
  logic [7:0] logCtrl [0:31];
  logic [7:0] logData [0:31];
  int   logN, stepIdx, mCnt, rxCnt;
  logic mActive, mAfter, pendFlag, pendStop;
  logic [7:0] mNext;

  function automatic logic [7:0] respond(input logic [7:0] c, input logic dw,
                                         input logic [7:0] d, input logic act, input logic aft);
    if (c[5]) return act ? 8'h10 : 8'h08;
    if (dw)   return aft ? (d[0] ? 8'h40 : 8'h18) : 8'h28;
    return c[2] ? 8'h50 : 8'h58;
  endfunction

  always @(posedge clk) begin
    if (mClr) begin
      logN <= 0; stepIdx <= 0; mCnt <= 0; rxCnt <= 0;
      mFlag <= 1'b0; mStatus <= 8'hF8; mActive <= 1'b0; mAfter <= 1'b0;
      pendFlag <= 1'b0; pendStop <= 1'b0; mRx <= 8'h00; mNext <= 8'h00;
    end else if (busCtrlWr) begin
      logCtrl[logN] <= busCtrl;
      logData[logN] <= busDataWr ? busTx : 8'h00;
      logN <= logN + 1;
      stepIdx <= stepIdx + 1;
      mFlag <= 1'b0;
      mCnt <= mDelay;
      if (busCtrl[4]) begin
        pendStop <= !stopHang; pendFlag <= 1'b0; mActive <= 1'b0;
      end else begin
        mNext <= (stepIdx == faultStep) ? 8'hEE : respond(busCtrl, busDataWr, busTx, mActive, mAfter);
        pendFlag <= (stepIdx != hangStep);
        pendStop <= 1'b0;
        if (busCtrl[5]) begin mActive <= 1'b1; mAfter <= 1'b1; end
        else if (busDataWr) mAfter <= 1'b0;
        else begin mRx <= 8'hA0 + 8'(rxCnt); rxCnt <= rxCnt + 1; end
      end
    end else if (mCnt != 0) begin
      mCnt <= mCnt - 1;
      if (mCnt == 1) begin
        if (pendFlag) begin mFlag <= 1'b1; mStatus <= mNext; end
        if (pendStop) mStatus <= 8'hF8;
      end
    end
  end

  // ---------------- write data source ----------------
  logic [7:0] txArr [0:7];
  int txIdx;
  assign txByte = txArr[txIdx[2:0]];
  always @(posedge clk) begin
    if (mClr) txIdx <= 0;
    else if (txTake) txIdx <= txIdx + 1;
  end

  // ---------------- output monitors (away from the active edge) ----------------
  logic [7:0] rxBuf [0:7];
  int rxN = 0, doneCnt = 0, doneWide = 0;
  logic [31:0] lastResult = '0;
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (mClr) rxN <= 0;
    else if (rxValid) begin rxBuf[rxN[2:0]] <= rxByte; rxN <= rxN + 1; end
    if (done) begin doneCnt <= doneCnt + 1; lastResult <= result; end
    if (done && prevDone) doneWide <= doneWide + 1;
    prevDone <= done;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic logIs(input string req, input int idx, input logic [7:0] c, input logic [7:0] d);
    chk(req, $sformatf("cmd%0d ctrl", idx), {24'h0, logCtrl[idx]}, {24'h0, c});
    chk(req, $sformatf("cmd%0d data", idx), {24'h0, logData[idx]}, {24'h0, d});
  endtask

  task automatic setup(input int dly, input int flt, input int hng, input logic sh);
    @(negedge clk);
    mDelay = dly; faultStep = flt; hangStep = hng; stopHang = sh;
    mClr = 1'b1;
    @(negedge clk);
    mClr = 1'b0;
  endtask

  task automatic runReq(input logic [1:0] op, input logic [6:0] chip, input logic [2:0] alen,
                        input logic [31:0] addr, input logic [LW-1:0] len);
    int d0;
    d0 = doneCnt;
    @(negedge clk);
    reqOp = op; reqChip = chip; reqAddrLen = alen; reqAddr = addr; reqLen = len;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (doneCnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    chk("R12", "busy after reset", {31'h0, busy}, 32'h0);
    chk("R12", "done after reset", {31'h0, done}, 32'h0);
  endtask

  task automatic tWrite();
    setup(3, 99, 99, 1'b0);
    txArr[0] = 8'hAB; txArr[1] = 8'hCD;
    runReq(2'd0, 7'h50, 3'd2, 32'h0000_1234, 8'd2);
    chk("R5", "command count", logN, 7);
    logIs("R3", 0, 8'h60, 8'h00);
    logIs("R4", 1, 8'h40, 8'hA0);
    logIs("R5", 2, 8'h40, 8'h34);   // least significant first
    logIs("R5", 3, 8'h40, 8'h12);
    logIs("R5", 4, 8'h40, 8'hAB);
    logIs("R5", 5, 8'h40, 8'hCD);
    logIs("R11", 6, 8'h50, 8'h00);
    chk("R5", "bytes taken", txIdx, 2);
    chk("R1", "write result", lastResult, 32'h0);
  endtask

  task automatic tReadAddr();
    setup(3, 99, 99, 1'b0);
    runReq(2'd1, 7'h21, 3'd1, 32'h0000_0007, 8'd3);
    chk("R6", "command count", logN, 9);
    logIs("R6", 0, 8'h60, 8'h00);
    logIs("R6", 1, 8'h40, 8'h42);
    logIs("R6", 2, 8'h40, 8'h07);
    logIs("R6", 3, 8'h60, 8'h00);   // repeated START, no STOP before it
    logIs("R4", 4, 8'h40, 8'h43);
    logIs("R8", 5, 8'h44, 8'h00);
    logIs("R8", 6, 8'h44, 8'h00);
    logIs("R8", 7, 8'h40, 8'h00);
    logIs("R11", 8, 8'h50, 8'h00);
    chk("R8", "rx count", rxN, 3);
    chk("R8", "rx0", {24'h0, rxBuf[0]}, 32'hA0);
    chk("R8", "rx1", {24'h0, rxBuf[1]}, 32'hA1);
    chk("R8", "rx2", {24'h0, rxBuf[2]}, 32'hA2);
    chk("R6", "read result", lastResult, 32'h0);
  endtask

  task automatic tReadNoAddr();
    setup(3, 99, 99, 1'b0);
    runReq(2'd1, 7'h33, 3'd0, 32'h0, 8'd1);
    chk("R7", "command count", logN, 4);
    logIs("R7", 0, 8'h60, 8'h00);
    logIs("R7", 1, 8'h40, 8'h67);
    logIs("R8", 2, 8'h40, 8'h00);
    chk("R7", "plain read result", lastResult, 32'h0);
    chk("R8", "rx single", {24'h0, rxBuf[0]}, 32'hA0);
  endtask

  task automatic tProbe();
    setup(3, 99, 99, 1'b0);
    runReq(2'd2, 7'h48, 3'd3, 32'hFFFF_FFFF, 8'd9);
    chk("R9", "command count", logN, 4);
    logIs("R9", 1, 8'h40, 8'h91);
    logIs("R9", 2, 8'h40, 8'h00);
    logIs("R9", 3, 8'h50, 8'h00);
    chk("R9", "probe result", lastResult, 32'h0);
  endtask

  task automatic tMismatch();
    setup(3, 3, 99, 1'b0);
    txArr[0] = 8'h11;
    runReq(2'd0, 7'h50, 3'd2, 32'h0000_1234, 8'd2);
    chk("R10", "command count", logN, 5);
    logIs("R10", 4, 8'h50, 8'h00);
    chk("R1", "mismatch word", lastResult, 32'h0148EE28);
    chk("R10", "no data taken", txIdx, 0);
  endtask

  task automatic tFlagTimeout();
    setup(3, 99, 1, 1'b0);
    runReq(2'd1, 7'h33, 3'd0, 32'h0, 8'd2);
    chk("R2", "command count", logN, 3);
    logIs("R11", 2, 8'h50, 8'h00);
    chk("R2", "timeout word", lastResult, 32'h02400840);
  endtask

  task automatic tWindowEdge();
    setup(PL * PI - 1, 99, 99, 1'b0);
    runReq(2'd2, 7'h48, 3'd0, 32'h0, 8'd1);
    chk("R2", "last poll accepted", lastResult, 32'h0);
    setup(PL * PI, 99, 99, 1'b0);
    runReq(2'd2, 7'h48, 3'd0, 32'h0, 8'd1);
    chk("R2", "one past window", lastResult, 32'h0260F808);
    chk("R10", "timeout goes to stop", logN, 2);
  endtask

  task automatic tStopHang();
    setup(3, 99, 99, 1'b1);
    runReq(2'd0, 7'h50, 3'd0, 32'h0, 8'd0);
    chk("R11", "command count", logN, 3);
    chk("R11", "stop timeout word", lastResult, 32'h025018F8);
    setup(3, 1, 99, 1'b1);
    runReq(2'd2, 7'h48, 3'd0, 32'h0, 8'd1);
    chk("R11", "first error kept", lastResult, 32'h0148EE40);
  endtask

  task automatic tBusyRefuse();
    int d0;
    setup(3, 99, 99, 1'b0);
    txArr[0] = 8'h5A; txArr[1] = 8'hC3;
    d0 = doneCnt;
    @(negedge clk);
    reqOp = 2'd0; reqChip = 7'h50; reqAddrLen = 3'd2; reqAddr = 32'h0000_1234; reqLen = 8'd2;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    reqOp = 2'd2; reqChip = 7'h11; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (doneCnt == d0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R12", "one done only", doneCnt - d0, 1);
    chk("R12", "commands unchanged", logN, 7);
    logIs("R12", 4, 8'h40, 8'h5A);
    chk("R12", "idle afterwards", {31'h0, busy}, 32'h0);
    chk("R12", "done never wide", doneWide, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mClr = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    mClr = 1'b0;
    @(negedge clk);
    tReset();
    tWrite();
    tReadAddr();
    tReadNoAddr();
    tProbe();
    tMismatch();
    tFlagTimeout();
    tWindowEdge();
    tStopHang();
    tBusyRefuse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule